// File: doc/BRIEF.md
# Three-Phase Charge-Transfer Clock Sequencer

This block produces the digital control levels that move charge through a charge-coupled pixel array. A start pulse opens an exposure window. During the window the three vertical phase lines stay in their charge-collecting pattern. When the window ends, the block moves one row into the readout register and then reads that register out, one column at a time. It repeats this for every row of the frame. After the last column of the last row it signals that the frame is complete and returns to the collecting pattern.

A vertical move takes four overlapping steps. Phase 1 drops first. Phase 3 then rises while phase 2 is still high. Phase 2 drops next. Phase 1 rises again while phase 3 is still high. Each step lasts a programmed number of clocks so that the charge has time to settle. The horizontal read gives one single-cycle strobe per column, and the pixel-valid flag is raised on the same cycle. The pixel stream has no ready input and accepts no back-pressure, because the charge moves at a fixed pace. The downstream sampler must take each pixel in its strobe cycle. The exposure length, step length, column count and row count are sampled when a start is accepted and stay fixed for the rest of that frame.

Top module: `ccd_phase_seq`

## Requirements
- R1: After reset the block is idle and drives the collecting pattern: phase1=1, phase2=1, phase3=0, with h_shift, pix_valid and frame_done all 0.
- R2: A start pulse seen in idle begins an exposure that lasts max(1, integ_len) cycles. The collecting pattern is held throughout, and all strobes stay low.
- R3: After the exposure, and again after each row's read, a vertical move runs four steps in a fixed order. The phase levels {phase1,phase2,phase3} are 010, then 011, then 001, then 101. Each step lasts max(1, step_len) cycles.
- R4: After the fourth step, max(1, col_count) consecutive cycles follow with h_shift=1 and pix_valid=1. The phases are held at the collecting pattern 110 during these cycles.
- R5: A vertical move followed by a horizontal read is repeated max(1, row_count) times per frame.
- R6: frame_done is 1 for exactly one cycle, directly after the last strobe of the last row. In that cycle the phases show 110. The block is then idle again.
- R7: A start pulse seen at any time other than idle, including the frame_done cycle, has no effect on the outputs.
- R8: integ_len, step_len, col_count and row_count are sampled with an accepted start. Changing them later does not alter the frame in progress.
- R9: At least one phase line is high in every cycle, so charge is never left without a holding well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start request, honoured only in idle |
| integ_len | input | INT_W | Exposure length in cycles (0 acts as 1) |
| step_len | input | STEP_W | Cycles per vertical step (0 acts as 1) |
| col_count | input | COL_W | Columns per row (0 acts as 1) |
| row_count | input | ROW_W | Rows per frame (0 acts as 1) |
| phase1 | output | 1 | Vertical phase 1 level (1 = hold, 0 = block) |
| phase2 | output | 1 | Vertical phase 2 level |
| phase3 | output | 1 | Vertical phase 3 level |
| h_shift | output | 1 | Horizontal shift strobe, one cycle per column |
| pix_valid | output | 1 | Pixel valid, high on each strobe cycle |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Every output comes straight from state registers. A start sampled at a clock edge therefore shows the first exposure cycle from that same edge, and each later step, strobe run and done pulse follows at the cycle count fixed by the sampled lengths. The bench model keeps a queue with one expected output word per cycle. The queue is filled when the model accepts a start and popped on each edge. The outputs are compared with the head of the queue at every falling edge, so each step boundary, the first and last strobe, and the done pulse are checked in the exact cycle they are due.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_EXPO  = 3'd1,
    SQ_VMOVE = 3'd2,
    SQ_HREAD = 3'd3,
    SQ_DONE  = 3'd4
  } seq_state_t;

  localparam int unsigned NUM_VSTEPS = 4;
  localparam int unsigned VSTEP_W    = $clog2(NUM_VSTEPS);
endpackage

// File: rtl/ccd_down_count.sv
module ccd_down_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ONE;
    end else if (load) begin
      cnt <= (load_val == '0) ? ONE : load_val;
    end else if (dec && cnt > ONE) begin
      cnt <= cnt - ONE;
    end
  end

  assign last = (cnt <= ONE);
endmodule

// File: rtl/ccd_phase_map.sv
module ccd_phase_map
  import ccd_seq_pkg::*;
(
  input  seq_state_t         state,
  input  logic [VSTEP_W-1:0] vstep,
  output logic               ph1,
  output logic               ph2,
  output logic               ph3
);
  always_comb begin
    {ph1, ph2, ph3} = 3'b110;
    if (state == SQ_VMOVE) begin
      case (vstep)
        2'd0:    {ph1, ph2, ph3} = 3'b010;
        2'd1:    {ph1, ph2, ph3} = 3'b011;
        2'd2:    {ph1, ph2, ph3} = 3'b001;
        default: {ph1, ph2, ph3} = 3'b101;
      endcase
    end
  end
endmodule

// File: rtl/ccd_phase_seq.sv
module ccd_phase_seq
  import ccd_seq_pkg::*;
#(
  parameter int unsigned INT_W  = 12,
  parameter int unsigned STEP_W = 4,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ROW_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [INT_W-1:0]  integ_len,
  input  logic [STEP_W-1:0] step_len,
  input  logic [COL_W-1:0]  col_count,
  input  logic [ROW_W-1:0]  row_count,
  output logic              phase1,
  output logic              phase2,
  output logic              phase3,
  output logic              h_shift,
  output logic              pix_valid,
  output logic              frame_done
);
  localparam logic [VSTEP_W-1:0] LAST_VSTEP = VSTEP_W'(NUM_VSTEPS - 1);

  seq_state_t         state, state_nx;
  logic [VSTEP_W-1:0] vstep, vstep_nx;
  logic [STEP_W-1:0]  step_len_q;
  logic [COL_W-1:0]   col_count_q;

  logic accept;
  logic expo_last, step_last, col_last, row_last;
  logic step_load, col_load, row_dec;

  assign accept = (state == SQ_IDLE) && start;

  // Exposure length is loaded from the port on the accepting edge.
  ccd_down_count #(.W(INT_W)) i_expo_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_val(integ_len),
    .dec(state == SQ_EXPO), .last(expo_last)
  );

  ccd_down_count #(.W(STEP_W)) i_step_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(step_load), .load_val(step_len_q),
    .dec(state == SQ_VMOVE), .last(step_last)
  );

  ccd_down_count #(.W(COL_W)) i_col_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(col_load), .load_val(col_count_q),
    .dec(state == SQ_HREAD), .last(col_last)
  );

  ccd_down_count #(.W(ROW_W)) i_row_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_val(row_count),
    .dec(row_dec), .last(row_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_len_q  <= '0;
      col_count_q <= '0;
    end else if (accept) begin
      step_len_q  <= step_len;
      col_count_q <= col_count;
    end
  end

  always_comb begin
    state_nx  = state;
    vstep_nx  = vstep;
    step_load = 1'b0;
    col_load  = 1'b0;
    row_dec   = 1'b0;
    unique case (state)
      SQ_IDLE: begin
        if (start) state_nx = SQ_EXPO;
      end
      SQ_EXPO: begin
        if (expo_last) begin
          state_nx  = SQ_VMOVE;
          vstep_nx  = '0;
          step_load = 1'b1;
        end
      end
      SQ_VMOVE: begin
        if (step_last) begin
          if (vstep == LAST_VSTEP) begin
            state_nx = SQ_HREAD;
            col_load = 1'b1;
          end else begin
            vstep_nx  = vstep + 1'b1;
            step_load = 1'b1;
          end
        end
      end
      SQ_HREAD: begin
        if (col_last) begin
          if (row_last) begin
            state_nx = SQ_DONE;
          end else begin
            state_nx  = SQ_VMOVE;
            vstep_nx  = '0;
            step_load = 1'b1;
            row_dec   = 1'b1;
          end
        end
      end
      default: state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      vstep <= '0;
    end else begin
      state <= state_nx;
      vstep <= vstep_nx;
    end
  end

  ccd_phase_map i_phase_map (
    .state(state), .vstep(vstep),
    .ph1(phase1), .ph2(phase2), .ph3(phase3)
  );

  assign h_shift    = (state == SQ_HREAD);
  assign pix_valid  = h_shift;
  assign frame_done = (state == SQ_DONE);
endmodule

// File: rtl/ccd_phase_seq_chk.sv
module ccd_phase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic phase1,
  input logic phase2,
  input logic phase3,
  input logic h_shift,
  input logic pix_valid,
  input logic frame_done
);
  AST_ONE_WELL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase1 || phase2 || phase3)); // R9
  AST_FIRST_STEP_KEEPS_P2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase1) |-> (phase2 && !phase3)); // R3
  AST_P3_RISE_OVERLAPS_P2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase3) |-> (phase2 && !phase1)); // R3
  AST_P2_FALL_LEAVES_P3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase2) |-> (phase3 && !phase1)); // R3
  AST_STROBE_AT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    h_shift |-> (phase1 && phase2 && !phase3 && pix_valid)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (!frame_done && !h_shift && phase1 && phase2 && !phase3)); // R6
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_done) |-> $past(h_shift)); // R6
endmodule

bind ccd_phase_seq ccd_phase_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n),
  .phase1(phase1), .phase2(phase2), .phase3(phase3),
  .h_shift(h_shift), .pix_valid(pix_valid), .frame_done(frame_done)
);

// File: tb/test_ccd_phase_seq.sv
module test_ccd_phase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] integ_len = '0;
  logic [3:0]  step_len = '0;
  logic [7:0]  col_count = '0;
  logic [7:0]  row_count = '0;
  logic phase1, phase2, phase3, h_shift, pix_valid, frame_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  ccd_phase_seq i_ccd_phase_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .integ_len(integ_len), .step_len(step_len),
    .col_count(col_count), .row_count(row_count),
    .phase1(phase1), .phase2(phase2), .phase3(phase3),
    .h_shift(h_shift), .pix_valid(pix_valid), .frame_done(frame_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected word {ph1,ph2,ph3,h_shift,pix_valid,frame_done} plus requirement number.
  localparam logic [5:0] IDLE_W = 6'b110_000;
  logic [5:0] exp_q[$];
  int         req_q[$];

  function automatic int at_least_one(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic push(logic [5:0] w, int req, int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(w);
      req_q.push_back(req);
    end
  endtask

  // Behavioural frame builder: R2 exposure, R3 steps, R4 read, R5 rows, R6 done.
  task automatic build_frame(int il, int sl, int c, int r);
    push(6'b110_000, 2, at_least_one(il));
    for (int row = 0; row < at_least_one(r); row++) begin
      push(6'b010_000, 3, at_least_one(sl));
      push(6'b011_000, 3, at_least_one(sl));
      push(6'b001_000, 3, at_least_one(sl));
      push(6'b101_000, 3, at_least_one(sl));
      push(6'b110_110, 4, at_least_one(c));
    end
    push(6'b110_001, 6, 1);
  endtask

  // Model update on each edge; a start when the queue is empty is accepted (R7, R8).
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      req_q.delete();
    end else if (exp_q.size() > 0) begin
      void'(exp_q.pop_front());
      void'(req_q.pop_front());
    end else if (start) begin
      build_frame(int'(integ_len), int'(step_len), int'(col_count), int'(row_count));
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      logic [5:0] expw;
      int         req;
      logic [5:0] act;
      expw = (exp_q.size() > 0) ? exp_q[0] : IDLE_W;
      req  = (exp_q.size() > 0) ? req_q[0] : 7;
      act  = {phase1, phase2, phase3, h_shift, pix_valid, frame_done};
      checks++;
      if (act !== expw) begin
        errors++;
        $display("FAIL R%0d cycle %0d: actual %b expected %b", req, cycles, act, expw);
      end
    end
  end

  task automatic start_frame(int il, int sl, int c, int r);
    @(negedge clk);
    integ_len = 12'(il); step_len = 4'(sl); col_count = 8'(c); row_count = 8'(r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_model_idle();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles: actual hung expected idle", cycles);
      finish_run();
    end
  end

  initial begin
    // R1: reset pattern, checked while reset is held and after release.
    repeat (3) @(negedge clk);
    checks++;
    if ({phase1, phase2, phase3, h_shift, pix_valid, frame_done} !== IDLE_W) begin
      errors++;
      $display("FAIL R1 in reset: actual %b expected %b",
               {phase1, phase2, phase3, h_shift, pix_valid, frame_done}, IDLE_W);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R5 R6: a typical frame.
    start_frame(3, 2, 4, 3);
    wait_model_idle();

    // Zero lengths all behave as one (R2, R3, R4, R5).
    start_frame(0, 0, 0, 0);
    wait_model_idle();

    // R7 and R8: restarts and changed inputs during a frame have no effect.
    start_frame(2, 3, 5, 2);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      start = k[0];
      integ_len = 12'd9; step_len = 4'd1; col_count = 8'd1; row_count = 8'd7;
    end
    start = 1'b0;
    while (exp_q.size() > 1) @(negedge clk);
    // R7: start held high on the frame_done cycle is ignored.
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);

    // Longer dwell and wider read.
    start_frame(7, 5, 9, 2);
    wait_model_idle();

    // Back-to-back: start on the first idle cycle after a frame.
    start_frame(1, 1, 2, 1);
    while (exp_q.size() > 0) @(negedge clk);
    start_frame(4, 2, 3, 2);
    wait_model_idle();

    finish_run();
  end
endmodule